// File: doc/BRIEF.md
# Grouped Virtual-Output-Queue Priority List

This block serves one input port of a combined input/output queued switch. It does not order individual cells. It orders the virtual output queues (one per output) that currently hold cells. All cells bound for one output sit as a contiguous run inside the input's priority order, so storing the relative order of the queues alone describes the full order of cells. The list therefore never holds more than one entry per output.

Each cycle the block accepts an optional arrival event, tagged with the destination output, and an optional departure event, naming the output whose queue loses its oldest cell. It keeps a saturating-checked count for every queue. The ordered list of non-empty queue identifiers is presented to the matching scheduler. For every list position the block also gives an eligibility flag, copied from the per-queue head-cell flag that the slackness logic supplies. Cell storage and slackness arithmetic live elsewhere.

An occupancy state machine tracks whether the list is empty, partly filled or full. Its states are OCC_EMPTY, OCC_PARTIAL and OCC_FULL. Its transitions are:
- FIRST_FILL: OCC_EMPTY to OCC_PARTIAL.
- DIRECT_FULL: OCC_EMPTY to OCC_FULL, possible only with a single output.
- LAST_DRAIN: OCC_PARTIAL to OCC_EMPTY.
- TOP_OFF: OCC_PARTIAL to OCC_FULL.
- ONE_DRAIN: OCC_FULL to OCC_PARTIAL.
- FULL_FLUSH: OCC_FULL to OCC_EMPTY.
- Hold transitions keep the current state.

Top module: `voq_prio_list`

## Requirements
- R1: After reset every queue count is 0, `list_len` is 0, both error flags are 0, `list_empty` is 1 and `list_full` is 0.
- R2: An accepted arrival to a queue whose count is 0 (after any same-cycle departure) places that queue's identifier at position 0 on the next cycle. Every earlier entry moves one position further back. Position p occupies bits [p*IDW +: IDW] of `list_ids`.
- R3: An accepted arrival to a non-empty queue adds one to its count and leaves `list_ids` and `list_len` unchanged.
- R4: The list holds exactly the non-empty queues, each once. `list_len` equals the number of set bits of `voq_nonempty` and never exceeds N_VOQ. Queue v's count is `voq_count[v*CNT_W +: CNT_W]`.
- R5: A departure that takes a queue from 1 cell to 0 removes its identifier. The entries behind it move one position toward the head, and `list_len` drops by one.
- R6: A departure from a queue holding more than one cell subtracts one from its count and leaves the order unchanged.
- R7: When an arrival and a departure occur in the same cycle, the departure is applied first and the arrival second. This holds even when both name the same queue, so a one-cell queue that drains and refills returns at position 0.
- R8: An arrival to a queue already at 2**CNT_W-1 cells is dropped. Counts and order stay unchanged, and `err_overflow` is set and stays set until reset.
- R9: A departure from an empty queue is dropped. Counts and order stay unchanged, and `err_underflow` is set and stays set until reset.
- R10: `list_active[p]` equals `head_active[v]` for the queue v at position p when p < `list_len`, and is 0 otherwise.
- R11: `list_empty` is 1 exactly when `list_len` is 0, and `list_full` is 1 exactly when `list_len` equals N_VOQ. Both are registered state, and both are valid in the same cycle as the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | A cell arrives this cycle |
| arr_dest | input | IDW | Destination output of the arriving cell |
| dep_valid | input | 1 | A cell leaves its queue this cycle |
| dep_dest | input | IDW | Queue that loses its oldest cell |
| head_active | input | N_VOQ | Per-queue eligibility of the head cell |
| list_ids | output | N_VOQ*IDW | Ordered queue identifiers, position 0 in the low bits |
| list_len | output | LENW | Number of valid list positions |
| list_active | output | N_VOQ | Eligibility per list position |
| voq_count | output | N_VOQ*CNT_W | Per-queue cell counts |
| voq_nonempty | output | N_VOQ | Per-queue non-empty flag |
| list_empty | output | 1 | Occupancy state is OCC_EMPTY |
| list_full | output | 1 | Occupancy state is OCC_FULL |
| err_overflow | output | 1 | Sticky: arrival refused at full count |
| err_underflow | output | 1 | Sticky: departure from an empty queue |

## Verification
A corrupted list shows up at `list_ids` on the first cycle after the offending event, because every position is compared against the expected order after each step. A wrong shift direction or a missed removal also puts `list_len` out of step with the number of non-empty queues in that same cycle. A count that drifts stays hidden until its queue should empty or fill. At that point the identifier either lingers, vanishes early or moves to the head at the wrong time, so the bench drains and refills queues to expose it.

// File: rtl/voq_pkg.sv
package voq_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

endpackage

// File: rtl/voq_cnt_bank.sv
module voq_cnt_bank #(
    parameter int N_VOQ = 4,
    parameter int CNT_W = 3,
    parameter int IDW   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arr_valid,
    input  logic [IDW-1:0]         arr_dest,
    input  logic                   dep_valid,
    input  logic [IDW-1:0]         dep_dest,
    output logic [N_VOQ*CNT_W-1:0] count_flat,
    output logic [N_VOQ-1:0]       nonempty,
    output logic                   remove_en,
    output logic                   insert_en,
    output logic                   err_overflow,
    output logic                   err_underflow
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [N_VOQ-1:0] dep_hit, arr_hit, drains, fills, ovf_v, unf_v;

    generate
        for (genvar v = 0; v < N_VOQ; v++) begin : g_voq
            logic [CNT_W-1:0] cnt_q, mid;
            logic             dsel, asel;

            assign dsel       = dep_valid && (dep_dest == IDW'(v));
            assign asel       = arr_valid && (arr_dest == IDW'(v));
            assign dep_hit[v] = dsel && (cnt_q != '0);
            assign unf_v[v]   = dsel && (cnt_q == '0);
            assign mid        = cnt_q - CNT_W'(dep_hit[v]);
            assign arr_hit[v] = asel && (mid != CNT_MAX);
            assign ovf_v[v]   = asel && (mid == CNT_MAX);
            assign drains[v]  = dep_hit[v] && (cnt_q == CNT_W'(1));
            assign fills[v]   = arr_hit[v] && (mid == '0);

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= mid + CNT_W'(arr_hit[v]);
            end

            assign count_flat[v*CNT_W +: CNT_W] = cnt_q;
            assign nonempty[v]                  = (cnt_q != '0);
        end
    endgenerate

    assign remove_en = |drains;
    assign insert_en = |fills;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_overflow  <= 1'b0;
            err_underflow <= 1'b0;
        end else begin
            err_overflow  <= err_overflow  | (|ovf_v);
            err_underflow <= err_underflow | (|unf_v);
        end
    end

endmodule

// File: rtl/voq_order_list.sv
module voq_order_list #(
    parameter int N_VOQ = 4,
    parameter int IDW   = 2,
    parameter int LENW  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 remove_en,
    input  logic [IDW-1:0]       remove_id,
    input  logic                 insert_en,
    input  logic [IDW-1:0]       insert_id,
    output logic [N_VOQ*IDW-1:0] ids_flat,
    output logic [LENW-1:0]      len,
    output logic [LENW-1:0]      next_len
);

    logic [IDW-1:0] ids_q   [N_VOQ];
    logic [IDW-1:0] shifted [N_VOQ];
    logic [IDW-1:0] ids_d   [N_VOQ];
    logic [LENW-1:0] len_q, len_mid;
    logic            found;
    int              pos;

    // Step 1: close the gap left by a drained queue.
    always_comb begin
        found = 1'b0;
        pos   = 0;
        for (int i = 0; i < N_VOQ; i++) begin
            if (!found && (i < int'(len_q)) && (ids_q[i] == remove_id)) begin
                found = 1'b1;
                pos   = i;
            end
        end
        for (int i = 0; i < N_VOQ - 1; i++) begin
            shifted[i] = (remove_en && found && i >= pos) ? ids_q[i+1] : ids_q[i];
        end
        shifted[N_VOQ-1] = (remove_en && found) ? '0 : ids_q[N_VOQ-1];
        len_mid = len_q - LENW'(remove_en && found);
    end

    // Step 2: a newly filled queue enters at the head.
    always_comb begin
        if (insert_en) begin
            ids_d[0] = insert_id;
            for (int i = 1; i < N_VOQ; i++) ids_d[i] = shifted[i-1];
            next_len = len_mid + LENW'(1);
        end else begin
            for (int i = 0; i < N_VOQ; i++) ids_d[i] = shifted[i];
            next_len = len_mid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            for (int i = 0; i < N_VOQ; i++) ids_q[i] <= '0;
        end else begin
            len_q <= next_len;
            for (int i = 0; i < N_VOQ; i++) ids_q[i] <= ids_d[i];
        end
    end

    generate
        for (genvar p = 0; p < N_VOQ; p++) begin : g_flat
            assign ids_flat[p*IDW +: IDW] = ids_q[p];
        end
    endgenerate

    assign len = len_q;

endmodule

// File: rtl/voq_occ_fsm.sv
module voq_occ_fsm
    import voq_pkg::*;
#(
    parameter int N_VOQ = 4,
    parameter int LENW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LENW-1:0] next_len,
    output logic            list_empty,
    output logic            list_full
);

    localparam logic [LENW-1:0] LEN_FULL = LENW'(N_VOQ);

    occ_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (next_len == LEN_FULL)  state_d = OCC_FULL;    // DIRECT_FULL
                else if (next_len != '0)   state_d = OCC_PARTIAL; // FIRST_FILL
            end
            OCC_PARTIAL: begin
                if (next_len == '0)            state_d = OCC_EMPTY; // LAST_DRAIN
                else if (next_len == LEN_FULL) state_d = OCC_FULL;  // TOP_OFF
            end
            OCC_FULL: begin
                if (next_len == '0)            state_d = OCC_EMPTY;   // FULL_FLUSH
                else if (next_len != LEN_FULL) state_d = OCC_PARTIAL; // ONE_DRAIN
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        list_empty = 1'b0;
        list_full  = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   list_empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    list_full  = 1'b1;
            default:     list_empty = 1'b1;
        endcase
    end

endmodule

// File: rtl/voq_prio_list.sv
module voq_prio_list #(
    parameter int N_VOQ = 4,
    parameter int CNT_W = 3,
    localparam int IDW  = (N_VOQ > 1) ? $clog2(N_VOQ) : 1,
    localparam int LENW = $clog2(N_VOQ + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arr_valid,
    input  logic [IDW-1:0]         arr_dest,
    input  logic                   dep_valid,
    input  logic [IDW-1:0]         dep_dest,
    input  logic [N_VOQ-1:0]       head_active,
    output logic [N_VOQ*IDW-1:0]   list_ids,
    output logic [LENW-1:0]        list_len,
    output logic [N_VOQ-1:0]       list_active,
    output logic [N_VOQ*CNT_W-1:0] voq_count,
    output logic [N_VOQ-1:0]       voq_nonempty,
    output logic                   list_empty,
    output logic                   list_full,
    output logic                   err_overflow,
    output logic                   err_underflow
);

    logic            remove_en, insert_en;
    logic [LENW-1:0] next_len;

    voq_cnt_bank #(.N_VOQ(N_VOQ), .CNT_W(CNT_W), .IDW(IDW)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .arr_valid     (arr_valid),
        .arr_dest      (arr_dest),
        .dep_valid     (dep_valid),
        .dep_dest      (dep_dest),
        .count_flat    (voq_count),
        .nonempty      (voq_nonempty),
        .remove_en     (remove_en),
        .insert_en     (insert_en),
        .err_overflow  (err_overflow),
        .err_underflow (err_underflow)
    );

    voq_order_list #(.N_VOQ(N_VOQ), .IDW(IDW), .LENW(LENW)) u_list (
        .clk       (clk),
        .rst_n     (rst_n),
        .remove_en (remove_en),
        .remove_id (dep_dest),
        .insert_en (insert_en),
        .insert_id (arr_dest),
        .ids_flat  (list_ids),
        .len       (list_len),
        .next_len  (next_len)
    );

    voq_occ_fsm #(.N_VOQ(N_VOQ), .LENW(LENW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_len   (next_len),
        .list_empty (list_empty),
        .list_full  (list_full)
    );

    generate
        for (genvar p = 0; p < N_VOQ; p++) begin : g_act
            assign list_active[p] = (LENW'(p) < list_len) &&
                                    head_active[list_ids[p*IDW +: IDW]];
        end
    endgenerate

endmodule

// File: rtl/voq_prio_list_chk.sv
module voq_prio_list_chk #(
    parameter int N_VOQ = 4,
    parameter int CNT_W = 3,
    localparam int IDW  = (N_VOQ > 1) ? $clog2(N_VOQ) : 1,
    localparam int LENW = $clog2(N_VOQ + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   arr_valid,
    input logic [IDW-1:0]         arr_dest,
    input logic                   dep_valid,
    input logic [IDW-1:0]         dep_dest,
    input logic [N_VOQ*IDW-1:0]   list_ids,
    input logic [LENW-1:0]        list_len,
    input logic [N_VOQ-1:0]       list_active,
    input logic [N_VOQ*CNT_W-1:0] voq_count,
    input logic [N_VOQ-1:0]       voq_nonempty,
    input logic                   list_empty,
    input logic                   list_full,
    input logic                   err_overflow,
    input logic                   err_underflow
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] arr_cnt, dep_cnt;
    assign arr_cnt = voq_count[int'(arr_dest)*CNT_W +: CNT_W];
    assign dep_cnt = voq_count[int'(dep_dest)*CNT_W +: CNT_W];

    p_len_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (list_len <= LENW'(N_VOQ)) && ($countones(voq_nonempty) == int'(list_len)));

    p_head_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && arr_cnt == '0) |=> (list_ids[IDW-1:0] == $past(arr_dest)));

    p_order_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && !dep_valid && arr_cnt != '0 && arr_cnt != CMAX)
        |=> ($stable(list_ids) && $stable(list_len)));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && !dep_valid && arr_cnt == CMAX)
        |=> (err_overflow && $stable(voq_count)));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |=> err_overflow);

    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_valid && !arr_valid && dep_cnt == '0)
        |=> (err_underflow && $stable(list_ids)));

    p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);

    p_idle_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (list_len == '0) |-> (list_active == '0));

    p_occ_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (list_empty == (list_len == '0)) && (list_full == (list_len == LENW'(N_VOQ))));

endmodule

bind voq_prio_list voq_prio_list_chk #(.N_VOQ(N_VOQ), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .arr_valid     (arr_valid),
    .arr_dest      (arr_dest),
    .dep_valid     (dep_valid),
    .dep_dest      (dep_dest),
    .list_ids      (list_ids),
    .list_len      (list_len),
    .list_active   (list_active),
    .voq_count     (voq_count),
    .voq_nonempty  (voq_nonempty),
    .list_empty    (list_empty),
    .list_full     (list_full),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
);

// File: tb/voq_prio_list_test.sv
module voq_prio_list_test;

    localparam int N     = 4;
    localparam int CW    = 3;
    localparam int IDW   = 2;
    localparam int LENW  = 3;
    localparam int NVEC  = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arr_valid = 1'b0, dep_valid = 1'b0;
    logic [IDW-1:0]   arr_dest = '0, dep_dest = '0;
    logic [N-1:0]     head_active = '0;
    logic [N*IDW-1:0] list_ids;
    logic [LENW-1:0]  list_len;
    logic [N-1:0]     list_active, voq_nonempty;
    logic [N*CW-1:0]  voq_count;
    logic             list_empty, list_full, err_overflow, err_underflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    voq_prio_list #(.N_VOQ(N), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .arr_valid(arr_valid), .arr_dest(arr_dest),
        .dep_valid(dep_valid), .dep_dest(dep_dest),
        .head_active(head_active),
        .list_ids(list_ids), .list_len(list_len), .list_active(list_active),
        .voq_count(voq_count), .voq_nonempty(voq_nonempty),
        .list_empty(list_empty), .list_full(list_full),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    always #10 clk = ~clk;

    // {arr_v, arr_d, dep_v, dep_d, expected ids (pos0 in low bits), expected len}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 2'd2, 1'b0, 2'd0, 8'h02, 3'd1},  // R2 fill 2        -> [2]
        {1'b1, 2'd1, 1'b0, 2'd0, 8'h09, 3'd2},  // R2 fill 1        -> [1,2]
        {1'b1, 2'd2, 1'b0, 2'd0, 8'h09, 3'd2},  // R3 join 2        -> [1,2]
        {1'b1, 2'd3, 1'b0, 2'd0, 8'h27, 3'd3},  // R2 fill 3        -> [3,1,2]
        {1'b0, 2'd0, 1'b1, 2'd1, 8'h0B, 3'd2},  // R5 drain 1 mid   -> [3,2]
        {1'b0, 2'd0, 1'b1, 2'd2, 8'h0B, 3'd2},  // R6 2 -> 1 cell   -> [3,2]
        {1'b1, 2'd0, 1'b1, 2'd3, 8'h08, 3'd2},  // R7 drain 3, fill 0 -> [0,2]
        {1'b1, 2'd2, 1'b1, 2'd2, 8'h02, 3'd2},  // R7 same queue    -> [2,0]
        {1'b1, 2'd1, 1'b0, 2'd0, 8'h09, 3'd3},  // R2               -> [1,2,0]
        {1'b1, 2'd3, 1'b0, 2'd0, 8'h27, 3'd4},  // R2 full          -> [3,1,2,0]
        {1'b0, 2'd0, 1'b1, 2'd0, 8'h27, 3'd3},  // R5 drain tail    -> [3,1,2]
        {1'b0, 2'd0, 1'b1, 2'd3, 8'h09, 3'd2},  // R5 drain head    -> [1,2]
        {1'b0, 2'd0, 1'b0, 2'd0, 8'h09, 3'd2}   // idle             -> [1,2]
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; results are sampled at the next falling edge.
    task automatic step(input logic av, input logic [IDW-1:0] ad,
                        input logic dv, input logic [IDW-1:0] dd);
        arr_valid = av; arr_dest = ad;
        dep_valid = dv; dep_dest = dd;
        @(negedge clk);
        arr_valid = 1'b0; dep_valid = 1'b0;
    endtask

    function automatic logic [7:0] pos_mask(input int len);
        logic [7:0] m = '0;
        for (int p = 0; p < N; p++) if (p < len) m[p*IDW +: IDW] = 2'b11;
        return m;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 len",       32'(list_len), 0);
        chk("R1 counts",    32'(voq_count), 0);
        chk("R1 errors",    32'({err_overflow, err_underflow}), 0);
        chk("R1 empty/full", 32'({list_empty, list_full}), 32'b10);

        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] m;
            step(VEC[k][16], VEC[k][15:14], VEC[k][13], VEC[k][12:11]);
            m = pos_mask(int'(VEC[k][2:0]));
            chk($sformatf("R2/R3/R5/R6/R7 order step %0d", k),
                32'(list_ids & m), 32'(VEC[k][10:3] & m));
            chk($sformatf("R4 len step %0d", k), 32'(list_len), 32'(VEC[k][2:0]));
            chk($sformatf("R11 flags step %0d", k), 32'({list_empty, list_full}),
                32'({VEC[k][2:0] == 3'd0, VEC[k][2:0] == 3'd4}));
        end

        // R3 / R6 / R7 counts after the table: queues 1 and 2 hold one cell each
        chk("R6 counts", 32'(voq_count), 32'h0_0_4_8 >> 0 == 0 ? 0 : 32'({3'd0, 3'd1, 3'd1, 3'd0}));
        chk("R4 nonempty", 32'(voq_nonempty), 32'b0110);

        // R10 eligibility per position: list [1,2], only queue 2 flagged
        head_active = 4'b0100;
        @(negedge clk);
        chk("R10 active", 32'(list_active), 32'b0010);
        head_active = 4'b1111;
        @(negedge clk);
        chk("R10 unused positions", 32'(list_active), 32'b0011);

        // R8 overflow: fill queue 1 to the limit, then one more
        for (int k = 0; k < 6; k++) step(1'b1, 2'd1, 1'b0, 2'd0);
        chk("R8 at limit", 32'(voq_count[1*CW +: CW]), 7);
        chk("R8 no flag yet", 32'(err_overflow), 0);
        step(1'b1, 2'd1, 1'b0, 2'd0);
        chk("R8 count held", 32'(voq_count[1*CW +: CW]), 7);
        chk("R8 flag", 32'(err_overflow), 1);
        chk("R8 order held", 32'(list_ids[3:0]), 32'h9);
        step(1'b0, 2'd0, 1'b0, 2'd0);
        chk("R8 sticky", 32'(err_overflow), 1);

        // R9 underflow from empty queue 0
        step(1'b0, 2'd0, 1'b1, 2'd0);
        chk("R9 flag", 32'(err_underflow), 1);
        chk("R9 len held", 32'(list_len), 2);
        chk("R9 count held", 32'(voq_count[0 +: CW]), 0);
        step(1'b0, 2'd0, 1'b0, 2'd0);
        chk("R9 sticky", 32'(err_underflow), 1);

        // R1 reset clears everything mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 re-reset", 32'({err_overflow, err_underflow, list_len}), 0);
        chk("R1 re-reset empty", 32'(list_empty), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule